// File: doc/BRIEF.md
# I2C START condition validator

This block sits behind the input synchronizers of an I2C slave and decides whether a falling SDA edge seen while SCL is high is a real START condition or a glitch. When it sees such an edge, it does not accept it at once. It looks at both bus lines in each of the following system-clock cycles and requires SDA low and SCL high at every look. The block accepts the START only after the programmed number of such samples has passed.

An 8-bit setup register sets the number of samples. Bit 7 selects multi-sample mode, and bits 6:0 give the length of the run. A simple write strobe loads the register, and its contents are always visible on a read bus. A validated START gives a one-cycle `start_valid` pulse, which tells the address receiver it may begin. A candidate that fails any sample gives a one-cycle `start_rejected` pulse, and the block returns to idle.

Top module: `i2c_start_qual`

## Requirements
- R1: After reset, `cfg_rdata` is 0x00 and both `start_valid` and `start_rejected` are low.
- R2: When `cfg_we` is high at a clock edge, `cfg_wdata` is stored, and from the next cycle on `cfg_rdata` shows the stored value.
- R3: A candidate START is detected in a cycle where `sda_i` is low, `sda_i` was high in the previous cycle, and `scl_i` is high. An SDA fall while SCL is low starts nothing, and SDA held low does not start anything again.
- R4: Suppose a candidate is detected in cycle c and N samples are needed. Samples are taken in cycles c+1 through c+N. If all N samples show `sda_i`=0 and `scl_i`=1, `start_valid` is high for exactly cycle c+N+1.
- R5: With setup bit 7 = 1, N equals the value of bits 6:0 plus one, so N runs from 1 to 128. A field of 0 gives a single sample.
- R6: With setup bit 7 = 0, N is 1 whatever bits 6:0 hold.
- R7: Suppose a sample in cycle k shows `sda_i`=1 or `scl_i`=0. Then `start_rejected` is high for exactly cycle k+1, and the block is idle in that cycle. A new candidate may be detected in that same cycle.
- R8: N is fixed by the register contents held before the candidate's edge. A write in the same cycle as the edge, or during sampling, takes effect only from the next candidate.
- R9: `start_valid` and `start_rejected` are never high together, and each is one cycle wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronized SCL level |
| sda_i | input | 1 | Synchronized SDA level |
| cfg_we | input | 1 | Setup register write strobe |
| cfg_wdata | input | 8 | Setup register write data: bit 7 multi-sample enable, bits 6:0 run length |
| cfg_rdata | output | 8 | Setup register contents |
| start_valid | output | 1 | One-cycle pulse: START confirmed |
| start_rejected | output | 1 | One-cycle pulse: candidate abandoned |

## Verification
Two functions can fall in the same cycle. The first pair is a rejection and a new candidate edge. The bench raises SDA for one sample, so the rejection comes one cycle later, and drops SDA again in that very cycle. The bench then expects the reject pulse and, after a full run of samples for the fresh edge, a valid pulse. The second pair is a register write and a candidate edge. The bench writes a different run length in the edge cycle and also in mid-run, and judges by the cycle of `start_valid`, which must follow the old length.

// File: rtl/i2c_start_qual_pkg.sv
package i2c_start_qual_pkg;

    // Width of the run-length field of the setup register
    localparam int unsigned SMPL_W = 7;
    localparam int unsigned CFG_W  = SMPL_W + 1;

    typedef struct packed {
        logic              multi_en;
        logic [SMPL_W-1:0] run_len;
    } setup_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SAMPLE = 2'd1,
        ST_VALID  = 2'd2
    } qual_state_e;

endpackage

// File: rtl/i2c_setup_reg.sv
module i2c_setup_reg
    import i2c_start_qual_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   we,
    input  setup_t wdata,
    output setup_t q
);

    setup_t setup_d, setup_q;

    always_comb begin
        setup_d = setup_q;
        if (we) begin
            setup_d = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            setup_q <= '0;
        end else begin
            setup_q <= setup_d;
        end
    end

    assign q = setup_q;

endmodule

// File: rtl/i2c_fall_det.sv
module i2c_fall_det (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic cand_o
);

    logic sda_prev_d, sda_prev_q;

    always_comb begin
        sda_prev_d = sda_i;
        // SDA falls while SCL stays high
        cand_o     = sda_prev_q & ~sda_i & scl_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_prev_q <= 1'b1;   // idle bus reads high
        end else begin
            sda_prev_q <= sda_prev_d;
        end
    end

endmodule

// File: rtl/i2c_qual_fsm.sv
module i2c_qual_fsm
    import i2c_start_qual_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   cand_i,
    input  logic   scl_i,
    input  logic   sda_i,
    input  setup_t cfg_i,
    output logic   valid_o,
    output logic   reject_o
);

    typedef struct packed {
        qual_state_e       st;
        logic [SMPL_W-1:0] left;
        logic              rej;
    } fsm_t;

    fsm_t fsm_d, fsm_q;
    logic bus_ok;

    always_comb begin
        bus_ok    = ~sda_i & scl_i;
        fsm_d     = fsm_q;
        fsm_d.rej = 1'b0;
        unique case (fsm_q.st)
            ST_IDLE: begin
                if (cand_i) begin
                    fsm_d.st   = ST_SAMPLE;
                    fsm_d.left = cfg_i.multi_en ? cfg_i.run_len : '0;
                end
            end
            ST_SAMPLE: begin
                if (bus_ok) begin
                    if (fsm_q.left == '0) begin
                        fsm_d.st = ST_VALID;
                    end else begin
                        fsm_d.left = fsm_q.left - 1'b1;
                    end
                end else begin
                    fsm_d.st  = ST_IDLE;
                    fsm_d.rej = 1'b1;
                end
            end
            ST_VALID: begin
                fsm_d.st = ST_IDLE;
            end
            default: begin
                fsm_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q <= '{st: ST_IDLE, left: '0, rej: 1'b0};
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign valid_o  = (fsm_q.st == ST_VALID);
    assign reject_o = fsm_q.rej;

endmodule

// File: rtl/i2c_start_qual.sv
module i2c_start_qual
    import i2c_start_qual_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_rdata,
    output logic             start_valid,
    output logic             start_rejected
);

    setup_t cfg_q;
    logic   cand;

    i2c_setup_reg u_setup (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (setup_t'(cfg_wdata)),
        .q     (cfg_q)
    );

    i2c_fall_det u_fall (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_i  (scl_i),
        .sda_i  (sda_i),
        .cand_o (cand)
    );

    i2c_qual_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cand_i   (cand),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .cfg_i    (cfg_q),
        .valid_o  (start_valid),
        .reject_o (start_rejected)
    );

    assign cfg_rdata = cfg_q;

endmodule

// File: rtl/i2c_start_qual_chk.sv
module i2c_start_qual_chk
    import i2c_start_qual_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             scl_i,
    input logic             sda_i,
    input logic             cfg_we,
    input logic [CFG_W-1:0] cfg_wdata,
    input logic [CFG_W-1:0] cfg_rdata,
    input logic             start_valid,
    input logic             start_rejected
);

    // R9
    pulses_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_valid && start_rejected));

    // R9
    valid_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_valid |=> !start_valid);

    // R9
    reject_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_rejected |=> !start_rejected);

    // R4
    valid_after_good_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_valid |-> $past(!sda_i && scl_i));

    // R7
    reject_after_bad_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_rejected |-> $past(sda_i || !scl_i));

    // R2
    cfg_write_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (cfg_rdata == $past(cfg_wdata)));

endmodule

bind i2c_start_qual i2c_start_qual_chk chk_i (.*);

// File: tb/i2c_start_qual_tb_top.sv
`timescale 1ns/1ps
module i2c_start_qual_tb_top;

    localparam int MAXL = 200;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       sda = 1'b1;
    logic       we = 1'b0;
    logic [7:0] wd = 8'h00;
    logic [7:0] rdata;
    logic       vld, rej;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic sda_v [MAXL];
    logic scl_v [MAXL];
    logic ev    [MAXL];
    logic er    [MAXL];

    always #2.5 clk = ~clk;

    i2c_start_qual dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .scl_i          (scl),
        .sda_i          (sda),
        .cfg_we         (we),
        .cfg_wdata      (wd),
        .cfg_rdata      (rdata),
        .start_valid    (vld),
        .start_rejected (rej)
    );

    function automatic int nsamp(logic [7:0] c);
        return c[7] ? int'(c[6:0]) + 1 : 1;
    endfunction

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp, int cyc);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s cycle %0d actual %0h expected %0h", req, cyc, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    task automatic clear_seq();
        for (int i = 0; i < MAXL; i++) begin
            sda_v[i] = 1'b1; scl_v[i] = 1'b1; ev[i] = 1'b0; er[i] = 1'b0;
        end
    endtask

    // Candidate edge at index 0, SDA held low through index h, then
    // disturbed (SDA high, or SCL low when glitch_scl) at h+1.
    task automatic build(int n, int h, bit glitch_scl, output int len);
        clear_seq();
        for (int i = 0; i <= h; i++) sda_v[i] = 1'b0;
        if (glitch_scl) begin
            sda_v[h+1] = 1'b0; scl_v[h+1] = 1'b0; scl_v[h+2] = 1'b0;
        end
        if (h >= n) ev[n+1] = 1'b1;
        else        er[h+2] = 1'b1;
        len = ((h > n) ? h : n) + 6;
    endtask

    // R9: both outputs compared every cycle, so overlap or a wide pulse fails
    task automatic run_seq(string tag, int len, int wr_idx, logic [7:0] wr_val);
        for (int i = 0; i <= len; i++) begin
            @(negedge clk);
            if (i > 0) begin
                chk(tag, {7'd0, vld}, {7'd0, ev[i]}, i);
                chk("R7", {7'd0, rej}, {7'd0, er[i]}, i);
            end
            sda = sda_v[i];
            scl = scl_v[i];
            we  = (i == wr_idx);
            wd  = wr_val;
        end
        @(negedge clk);
        we = 1'b0; sda = 1'b1; scl = 1'b1;
    endtask

    task automatic write_cfg(logic [7:0] v);
        @(negedge clk);
        we = 1'b1; wd = v;
        @(negedge clk);
        we = 1'b0;
        chk("R2", rdata, v, 0);
    endtask

    task automatic scen(string tag, logic [7:0] c, int h, bit g);
        int len;
        build(nsamp(c), h, g, len);
        run_seq(tag, len, -1, 8'h00);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        int len;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", rdata, 8'h00, 0);
        chk("R1", {6'd0, vld, rej}, 8'h00, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1", {6'd0, vld, rej}, 8'h00, 0);

        // R6: reset value gives a single sample
        scen("R6", 8'h00, 1, 1'b0);
        scen("R6", 8'h00, 0, 1'b0);

        // R5: multi-sample runs
        write_cfg(8'h85);
        scen("R5", 8'h85, 6, 1'b0);
        scen("R5", 8'h85, 5, 1'b0);
        scen("R5", 8'h85, 2, 1'b1);

        // R6: enable clear, field ignored
        write_cfg(8'h05);
        scen("R6", 8'h05, 1, 1'b0);
        scen("R6", 8'h05, 0, 1'b1);

        // R5: field zero still one sample; longest run
        write_cfg(8'h80);
        scen("R5", 8'h80, 0, 1'b0);
        scen("R5", 8'h80, 1, 1'b0);
        write_cfg(8'hFF);
        scen("R5", 8'hFF, 128, 1'b0);
        scen("R5", 8'hFF, 127, 1'b0);

        // R3: SDA falls while SCL low, then SCL rises with SDA held low
        clear_seq();
        scl_v[0] = 1'b0;
        scl_v[1] = 1'b0; sda_v[1] = 1'b0;
        for (int i = 2; i < 20; i++) sda_v[i] = 1'b0;
        run_seq("R3", 24, -1, 8'h00);

        // R8: write in mid-run, then write in the edge cycle
        write_cfg(8'h83);
        build(4, 4, 1'b0, len);
        run_seq("R8", len, 2, 8'h80);
        chk("R8", rdata, 8'h80, 0);
        build(1, 3, 1'b0, len);
        run_seq("R8", len, 0, 8'h83);
        chk("R8", rdata, 8'h83, 0);
        scen("R8", 8'h83, 4, 1'b0);

        // R7: reject and a fresh candidate edge in the same cycle
        write_cfg(8'h82);
        clear_seq();
        sda_v[0] = 1'b0; sda_v[1] = 1'b0;
        for (int i = 3; i <= 7; i++) sda_v[i] = 1'b0;
        er[3] = 1'b1;
        ev[7] = 1'b1;
        run_seq("R7", 11, -1, 8'h00);

        // R4: random settings and hold lengths
        for (int t = 0; t < 60; t++) begin
            logic [7:0] c;
            int n;
            c[7]   = 1'($urandom % 2);
            c[6:0] = (t % 10 == 9) ? 7'($urandom % 128) : 7'($urandom % 10);
            write_cfg(c);
            n = nsamp(c);
            scen("R4", c, int'($urandom % (n + 3)), 1'($urandom % 2));
        end

        summary();
    end

endmodule